// File: doc/BRIEF.md
# Shared Waveform Generator PWM Bank

This block drives 33 blink/PWM outputs from a pool of eight waveform generators. Channels 0 to 15 feed direct pins and channels 16 to 32 feed a serial-output stage, which lies outside this block. Each generator holds a period in coarse ticks and a pair of step counts, one for the high phase and one for the low phase. Each channel holds a small map entry. The entry picks one generator and gates it onto the channel. Many channels can share one generator, so up to eight different waveforms run at the same time.

Software programs the block through a write-only word interface. The map entries are read back in parallel. A slow tick strobe sets the time base. Each generator stretches every step to `period` ticks, so a full waveform of high + low = 255 steps lasts `period` times 255 ticks. With the tick at 255 strobes per 4 ms, one period unit is 4 ms. A rewritten generator finishes the period it is running before the new values take effect, so reprogramming never produces a short or torn pulse.

Top module: `pwm_bank`

## Requirements
- R1: While reset is held and after it is released with no writes, every channel output is 0 and the map read-back is all zeros.
- R2: Word addresses decode as follows. Addresses 0 and 1 hold period fields, four generators per word, with generator g at bits 8*(g mod 4)+7:8*(g mod 4) of word g/4. Addresses 2 to 5 hold step counts, two generators per word. Generator g uses half 16*(g mod 2) of word 2+g/2; within that half, bits 7:0 are the high count and bits 15:8 the low count. Addresses 6 to 10 hold map entries. Channel c uses the nibble at bits 4*(c mod 8)+3:4*(c mod 8) of word 6+c/8; bit 3 of the nibble is the enable and bits 2:0 are the generator index.
- R3: A generator with period P (1..250), high count H and low count L drives high for H*P ticks and then low for L*P ticks, and repeats. Each period begins with the high phase.
- R4: A written period above 250 behaves exactly as 250.
- R5: A generator whose period is 0, or whose high and low counts are both 0, holds its output low.
- R6: H = 255 with L = 0 gives a constant-high output.
- R7: A rewrite of a running generator's period or step counts takes effect only after the period in progress has completed. An idle generator takes the new values at once.
- R8: An enabled channel carries its selected generator. A channel with its enable bit clear drives 0, and other channels on the same generator are not affected.
- R9: The map read-back shows every entry exactly as written, disabled entries included, at bit 4*c for channel c.
- R10: All channels that select the same generator carry identical waveforms in every cycle.
- R11: A channel output changes only in the cycle after a sampled tick strobe, or within two cycles after a register write.
- R12: A write to an address outside 0 to 10 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle time-base strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Word address of the write |
| wrData | input | 32 | Write data |
| chanOut | output | 33 | Channel outputs; bit c is channel c |
| mapState | output | 132 | Map entries read back, channel c at bits 4c+3:4c |

## Verification
The main function is tried with a table of generator settings. The table mixes short and long periods, high-heavy and low-heavy duty, a period above the limit, the limit itself, and channels in every map word, including the lone channel in the last word. Each setting is measured as a high run and a low run in clocks. This separates a wrong tick scale, swapped high and low fields, wrong field packing, missing clamping, and wrong routing. Directed cases cover the rest. A duty rewrite in mid-period must leave the current low phase at its old length. A disabled entry with a nonzero index must stay low while its sibling keeps running. Period 0 and zero counts must stay low, full scale must stay high, and writes to unmapped addresses must change nothing.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int NUM_GEN          = 8;
  localparam int NUM_CH           = 33;
  localparam int FLD_W            = 8;
  localparam int PERIOD_LIMIT     = 250;
  localparam int GEN_SEL_W        = $clog2(NUM_GEN);
  localparam int NIB_W            = 4;
  localparam int DATA_W           = 32;
  localparam int ADDR_W           = 4;
  localparam int CH_PER_WORD      = DATA_W / NIB_W;
  localparam int GEN_PER_PER_WORD = DATA_W / FLD_W;
  localparam int GEN_PER_DUTY_WRD = DATA_W / (2 * FLD_W);
  localparam int PER_WORDS        = NUM_GEN / GEN_PER_PER_WORD;
  localparam int DUTY_WORDS       = NUM_GEN / GEN_PER_DUTY_WRD;
  localparam int MAP_WORDS        = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;
  localparam int PER_BASE         = 0;
  localparam int DUTY_BASE        = PER_BASE + PER_WORDS;
  localparam int MAP_BASE         = DUTY_BASE + DUTY_WORDS;
  localparam int MAP_BITS         = NUM_CH * NIB_W;

  // Write strobes from the decoder to the datapath, one bit per word.
  typedef struct packed {
    logic [PER_WORDS-1:0]  perLd;
    logic [DUTY_WORDS-1:0] dutyLd;
    logic [MAP_WORDS-1:0]  mapLd;
  } wrStrb_t;
endpackage

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
  import pwm_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrb_t           strb
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      for (int i = 0; i < PER_WORDS; i++)
        if (wrAddr == ADDR_W'(PER_BASE + i)) strb.perLd[i] = 1'b1;
      for (int i = 0; i < DUTY_WORDS; i++)
        if (wrAddr == ADDR_W'(DUTY_BASE + i)) strb.dutyLd[i] = 1'b1;
      for (int i = 0; i < MAP_WORDS; i++)
        if (wrAddr == ADDR_W'(MAP_BASE + i)) strb.mapLd[i] = 1'b1;
    end
  end
endmodule

// File: rtl/pwm_bank_gen.sv
module pwm_bank_gen
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             perLd,
  input  logic             dutyLd,
  input  logic [FLD_W-1:0] perIn,
  input  logic [FLD_W-1:0] hiIn,
  input  logic [FLD_W-1:0] loIn,
  output logic             waveOut
);
  localparam int TOT_W = FLD_W + 1;

  logic [FLD_W-1:0] shPer, shHi, shLo;
  logic [FLD_W-1:0] acPer, acHi, acLo;
  logic [FLD_W-1:0] psc;
  logic [TOT_W-1:0] stp, total;
  logic             idle, lastPsc, lastStp, reload;

  function automatic logic [FLD_W-1:0] clampPer(input logic [FLD_W-1:0] v);
    return (v > FLD_W'(PERIOD_LIMIT)) ? FLD_W'(PERIOD_LIMIT) : v;
  endfunction

  assign total   = {1'b0, acHi} + {1'b0, acLo};
  assign idle    = (acPer == '0) || (total == '0);
  assign lastPsc = (psc == acPer - FLD_W'(1));
  assign lastStp = (stp == total - TOT_W'(1));
  assign reload  = idle || (tick && lastPsc && lastStp);

  // Shadow copies written by software
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPer <= '0;
      shHi  <= '0;
      shLo  <= '0;
    end else begin
      if (perLd) shPer <= clampPer(perIn);
      if (dutyLd) begin
        shHi <= hiIn;
        shLo <= loIn;
      end
    end
  end

  // Active copy, prescaler and step counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acPer <= '0;
      acHi  <= '0;
      acLo  <= '0;
      psc   <= '0;
      stp   <= '0;
    end else if (reload) begin
      acPer <= shPer;
      acHi  <= shHi;
      acLo  <= shLo;
      psc   <= '0;
      stp   <= '0;
    end else if (tick) begin
      if (lastPsc) begin
        psc <= '0;
        stp <= stp + TOT_W'(1);
      end else begin
        psc <= psc + FLD_W'(1);
      end
    end
  end

  assign waveOut = !idle && (stp < {1'b0, acHi});
endmodule

// File: rtl/pwm_bank_dp.sv
module pwm_bank_dp
  import pwm_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickIn,
  input  wrStrb_t             strb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [NUM_CH-1:0]   chanOut,
  output logic [MAP_BITS-1:0] mapState
);
  logic [NUM_GEN-1:0]  genWave;
  logic [MAP_BITS-1:0] mapReg;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int PER_OFS  = FLD_W * (g % GEN_PER_PER_WORD);
    localparam int DUTY_OFS = 2 * FLD_W * (g % GEN_PER_DUTY_WRD);
    pwm_bank_gen u_gen (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tickIn),
      .perLd  (strb.perLd[g / GEN_PER_PER_WORD]),
      .dutyLd (strb.dutyLd[g / GEN_PER_DUTY_WRD]),
      .perIn  (wrData[PER_OFS +: FLD_W]),
      .hiIn   (wrData[DUTY_OFS +: FLD_W]),
      .loIn   (wrData[DUTY_OFS + FLD_W +: FLD_W]),
      .waveOut(genWave[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int NIB_OFS = NIB_W * (c % CH_PER_WORD);
    logic [GEN_SEL_W-1:0] sel;
    logic                 en;

    always_ff @(posedge clk) begin
      if (!rstN) mapReg[c*NIB_W +: NIB_W] <= '0;
      else if (strb.mapLd[c / CH_PER_WORD])
        mapReg[c*NIB_W +: NIB_W] <= wrData[NIB_OFS +: NIB_W];
    end

    assign en         = mapReg[c*NIB_W + NIB_W - 1];
    assign sel        = mapReg[c*NIB_W +: GEN_SEL_W];
    assign chanOut[c] = en & genWave[sel];
  end

  assign mapState = mapReg;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickIn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [NUM_CH-1:0]   chanOut,
  output logic [MAP_BITS-1:0] mapState
);
  wrStrb_t strb;

  pwm_bank_ctrl u_ctrl (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .strb  (strb)
  );

  pwm_bank_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickIn  (tickIn),
    .strb    (strb),
    .wrData  (wrData),
    .chanOut (chanOut),
    .mapState(mapState)
  );
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                tickIn,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [DATA_W-1:0]   wrData,
  input logic [NUM_CH-1:0]   chanOut,
  input logic [MAP_BITS-1:0] mapState
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dis
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
      !mapState[c*NIB_W + NIB_W - 1] |-> !chanOut[c]); // R8
  end

  for (genvar w = 0; w < MAP_WORDS; w++) begin : g_map
    localparam int LO  = w * DATA_W;
    localparam int WID = (MAP_BITS - LO < DATA_W) ? (MAP_BITS - LO) : DATA_W;
    AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == ADDR_W'(MAP_BASE + w)) |=>
        mapState[LO +: WID] == $past(wrData[WID-1:0])); // R9
  end

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(mapState)); // R12

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tickIn) && !$past(wrEn) && !$past(wrEn, 2)) |-> $stable(chanOut)); // R11
endmodule

bind pwm_bank pwm_bank_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tickIn  (tickIn),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .chanOut (chanOut),
  .mapState(mapState)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int TICK_DIV = 4;
  localparam int LIMIT    = 6000;
  localparam int A_PER    = 0;
  localparam int A_DUTY   = 2;
  localparam int A_MAP    = 6;
  localparam int VEC_N    = 5;
  // gen, channel, period, high, low, expected high ticks, expected low ticks
  localparam int TBL [VEC_N][7] = '{
    '{0, 0,   1, 2, 3,   2,   3},
    '{1, 5,   2, 3, 1,   6,   2},
    '{7, 20,  3, 1, 4,   3,  12},
    '{3, 32, 255, 1, 2, 250, 500},
    '{2, 16, 250, 1, 1, 250, 250}
  };

  logic         clk = 0;
  logic         rstN = 0;
  logic         tickIn = 0;
  logic         wrEn = 0;
  logic [3:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic [32:0]  chanOut;
  logic [131:0] mapState;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [31:0] perWord [2];
  logic [31:0] dutyWord [4];
  logic [31:0] mapWord [5];

  pwm_bank u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .chanOut(chanOut), .mapState(mapState)
  );

  always #10 clk = ~clk;

  initial begin : tickGen
    int cnt = 0;
    forever begin
      @(negedge clk);
      tickIn = (cnt == TICK_DIV - 1);
      cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input logic [31:0] data);
    wrEn = 1; wrAddr = 4'(addr); wrData = data;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic setPer(input int g, input int per);
    perWord[g/4][8*(g%4) +: 8] = 8'(per);
    writeReg(A_PER + g/4, perWord[g/4]);
  endtask

  task automatic setDuty(input int g, input int hi, input int lo);
    dutyWord[g/2][16*(g%2) +: 16] = {8'(lo), 8'(hi)};
    writeReg(A_DUTY + g/2, dutyWord[g/2]);
  endtask

  task automatic setMap(input int ch, input bit en, input int sel);
    mapWord[ch/8][4*(ch%8) +: 4] = {en, 3'(sel)};
    writeReg(A_MAP + ch/8, mapWord[ch/8]);
  endtask

  task automatic waitLevel(input int ch, input logic lvl);
    int n = 0;
    while (chanOut[ch] !== lvl && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic countLevel(input int ch, input logic lvl, output int c);
    c = 0;
    do begin
      c++;
      @(negedge clk);
    end while (chanOut[ch] === lvl && c < LIMIT);
  endtask

  task automatic measureRun(input int ch, output int hiClk, output int loClk);
    waitLevel(ch, 1'b0);
    waitLevel(ch, 1'b1);
    countLevel(ch, 1'b1, hiClk);
    countLevel(ch, 1'b0, loClk);
  endtask

  task automatic holdCheck(input int ch, input logic lvl, input int cycles, input string req);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (chanOut[ch] !== lvl) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin : stim
    int hiC, loC, bad;
    logic [131:0] mapSnap;
    logic [32:0]  prevOut;
    foreach (perWord[i]) perWord[i] = '0;
    foreach (dutyWord[i]) dutyWord[i] = '0;
    foreach (mapWord[i]) mapWord[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(chanOut == '0, "R1 outputs in reset", int'(chanOut[31:0]), 0);
    rstN = 1;
    repeat (20) @(negedge clk);
    check(chanOut == '0, "R1 outputs after reset", int'(chanOut[31:0]), 0);
    check(mapState == '0, "R1 map after reset", int'(mapState[31:0]), 0);

    // R2 R3 R4: table of settings, each on a fresh generator
    for (int v = 0; v < VEC_N; v++) begin
      setPer(TBL[v][0], TBL[v][2]);
      setDuty(TBL[v][0], TBL[v][3], TBL[v][4]);
      setMap(TBL[v][1], 1'b1, TBL[v][0]);
      measureRun(TBL[v][1], hiC, loC);
      check(hiC == TBL[v][5] * TICK_DIV, "R2/R3/R4 high run", hiC, TBL[v][5] * TICK_DIV);
      check(loC == TBL[v][6] * TICK_DIV, "R2/R3/R4 low run", loC, TBL[v][6] * TICK_DIV);
    end

    // R10: sharing one generator
    setMap(1, 1'b1, 0);
    setMap(17, 1'b1, 0);
    check(mapState[4*17 +: 4] == 4'b1000, "R9 readback ch17", int'(mapState[4*17 +: 4]), 8);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (chanOut[1] !== chanOut[0] || chanOut[17] !== chanOut[0]) bad++;
    end
    check(bad == 0, "R10 shared waveform mismatches", bad, 0);

    // R8 R9: disable a sharer with a nonzero index kept in the entry
    setMap(1, 1'b0, 5);
    check(mapState[4*1 +: 4] == 4'b0101, "R9 disabled entry readback", int'(mapState[4*1 +: 4]), 5);
    holdCheck(1, 1'b0, 200, "R8 disabled channel high cycles");
    measureRun(0, hiC, loC);
    check(hiC == 2 * TICK_DIV && loC == 3 * TICK_DIV, "R8 sibling high run", hiC, 2 * TICK_DIV);

    // R7: rewrite during the high phase, current period keeps old values
    waitLevel(0, 1'b0);
    waitLevel(0, 1'b1);
    setDuty(0, 4, 1);
    waitLevel(0, 1'b0);
    countLevel(0, 1'b0, loC);
    check(loC == 3 * TICK_DIV, "R7 low phase of running period", loC, 3 * TICK_DIV);
    countLevel(0, 1'b1, hiC);
    check(hiC == 4 * TICK_DIV, "R7 high phase after update", hiC, 4 * TICK_DIV);
    countLevel(0, 1'b0, loC);
    check(loC == 1 * TICK_DIV, "R7 low phase after update", loC, TICK_DIV);

    // R7: idle generator takes values at once
    setDuty(4, 1, 1);
    setPer(4, 1);
    setMap(2, 1'b1, 4);
    measureRun(2, hiC, loC);
    check(hiC == TICK_DIV && loC == TICK_DIV, "R7 idle generator run", hiC, TICK_DIV);

    // R5: period 0 and zero counts hold low
    setPer(5, 0);
    setDuty(5, 100, 155);
    setMap(3, 1'b1, 5);
    holdCheck(3, 1'b0, 600, "R5 period zero high cycles");
    setPer(6, 2);
    setDuty(6, 0, 0);
    setMap(4, 1'b1, 6);
    holdCheck(4, 1'b0, 600, "R5 zero counts high cycles");

    // R6: full scale on a running generator
    setDuty(7, 255, 0);
    repeat (100) @(negedge clk);
    holdCheck(20, 1'b1, 600, "R6 constant high low cycles");

    // R12: unmapped addresses
    mapSnap = mapState;
    writeReg(11, 32'hFFFF_FFFF);
    writeReg(15, 32'hFFFF_FFFF);
    @(negedge clk);
    check(mapState == mapSnap, "R12 map after stray write", int'(mapState[31:0]), int'(mapSnap[31:0]));
    measureRun(0, hiC, loC);
    check(hiC == 4 * TICK_DIV && loC == TICK_DIV, "R12 generator after stray write", hiC, 4 * TICK_DIV);

    // R11: with no writes, outputs move only after a sampled tick
    bad = 0;
    @(posedge clk); #2;
    prevOut = chanOut;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #2;
      if (chanOut !== prevOut && tickIn !== 1'b1) bad++;
      prevOut = chanOut;
    end
    check(bad == 0, "R11 changes without tick", bad, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule